// File: doc/BRIEF.md
# Two-Wire Register Slave with Stall Watchdog

This block is a slave on a two-wire serial bus (I2C-compatible) inside a synchronous design. SCL and SDA are sampled in the system clock domain. Each line goes through a two-stage synchronizer and then an edge detector. The block never drives a line high: it only asserts an open-drain pull-down enable for SDA. It answers one 7-bit device address. The first byte of a write sets an internal pointer. Reads return the 16-bit word selected by that pointer, low byte first. The word comes from a small register file, a version command or an alert-source command.

A master sets the pointer with a short write and then reads in a second transaction, or after a repeated START. A watchdog counts system clocks from the latest START. If a transaction is still open when the count reaches `LOCK_CYC`, the whole block returns to its power-up state.

The controller states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WR_BYTE`, `ST_WR_ACK`, `ST_RD_BYTE`, `ST_RD_ACK` and `ST_IGNORE`. The transitions are as follows:
- From any state: START goes to `ST_ADDR`, and STOP or a watchdog expiry goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, or to `ST_IGNORE` on any other address.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` when R/W=0, or to `ST_RD_BYTE` when R/W=1.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD_BYTE` when the master ACKs, or to `ST_IGNORE` when it NACKs.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START, including a repeated START, begins address reception. The address byte is seven address bits, MSB first, followed by R/W (1 = read). It is ACKed only when the address equals `DEV_ADDR`. With any other address, SDA is never pulled low until the next START or STOP.
- R2: In a write, the slave ACKs every byte. The first byte after the address loads the pointer. Each later byte in the same transaction is stored into the register the pointer selects; the pointer does not advance.
- R3: In a read, the slave sends the selected word low byte first and then high byte, each byte MSB first.
- R4: After the high byte of a word, the next byte read in the same transaction is the low byte of that word again.
- R5: When the master NACKs a read byte, the slave releases SDA and drives nothing more until the next START.
- R6: Pointer value 09h reads as the version word 0100h.
- R7: Pointer value 0Ah reads as {00h, `alert_src`} while `alert_valid` is high, and as 8103h when it is low.
- R8: Pointer values 0 to `NREG`-1 read as {00h, register}. Other pointer values read as 0000h. Data bytes written while the pointer holds a value other than 0 to `NREG`-1 change nothing.
- R9: SDA is only ever pulled low or released (`sda_oe`=1 means pull low). The pull-down changes only while SCL is low, or in the cycle after a START, STOP or watchdog event.
- R10: If `LOCK_CYC` system clocks pass after a START with no STOP, the block returns to its reset state: idle, pointer 0, registers 0, SDA released.
- R11: A STOP returns the controller to idle. The pointer keeps its value from one transaction to the next.
- R12: After reset, `sda_oe` is 0, the pointer is 0 and every register reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| alert_valid | input | 1 | An alert is pending |
| alert_src | input | 8 | Identifier of the register that raised the alert |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The hardest case to reach from the ports is the watchdog expiry. It happens only in the middle of a transaction that has already been ACKed, with SCL held low long after the pointer byte. Its effect is visible only in later transactions. The bench builds a small `LOCK_CYC`, writes non-zero registers and opens a write that it then stalls. It then reads back the pointer and a register to show that both returned to zero. A second awkward case is the cycle-level rule on SDA. To cover it, a monitor checks on every clock that the pull-down appears only in the bit slots where the master expects the slave to drive.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    localparam logic [7:0]  CMD_VERSION   = 8'h09;
    localparam logic [7:0]  CMD_ALERT     = 8'h0A;
    localparam logic [15:0] VERSION_WORD  = 16'h0100;
    localparam logic [15:0] NO_ALERT_WORD = 16'h8103;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES:0] scl_sh;
    logic [SYNC_STAGES:0] sda_sh;
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];
    assign scl_p = scl_sh[SYNC_STAGES];
    assign sda_p = sda_sh[SYNC_STAGES];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_lockout_timer.sv
module i2c_lockout_timer #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = busy && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!busy || restart || expired)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_LOCK_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT)); // R10
endmodule

// File: rtl/i2c_cmd_map.sv
module i2c_cmd_map
    import i2c_slv_pkg::*;
#(
    parameter int NREG = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr_en,
    input  logic [7:0]  wr_ptr,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  rd_ptr,
    input  logic        alert_valid,
    input  logic [7:0]  alert_src,
    output logic [15:0] word_o
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [7:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (clr)
                regs[i] <= '0;
            else if (wr_en && (wr_ptr == 8'(i)))
                regs[i] <= wr_data;
        end
    end

    always_comb begin
        if (rd_ptr == CMD_VERSION)
            word_o = VERSION_WORD;
        else if (rd_ptr == CMD_ALERT)
            word_o = alert_valid ? {8'h00, alert_src} : NO_ALERT_WORD;
        else if (rd_ptr < 8'(NREG))
            word_o = {8'h00, regs[rd_ptr[IW-1:0]]};
        else
            word_o = 16'h0000;
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2C,
    parameter int         NREG        = 4,
    parameter int         LOCK_CYC    = 5_000_000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       alert_valid,
    input  logic [7:0] alert_src,
    output logic       sda_oe
);
    slv_state_e state, nxt;

    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic        tmo;
    logic [3:0]  bitcnt;
    logic [7:0]  rx_sh;
    logic [7:0]  tx_sh;
    logic [7:0]  ptr;
    logic        ptr_pending;
    logic        hi_sel;
    logic        mst_nack;
    logic        wr_en;
    logic [15:0] word;
    logic [7:0]  cur_byte;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_lockout_timer #(.LIMIT(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .busy(state != ST_IDLE),
        .restart(start_det), .expired(tmo)
    );

    assign wr_en = (state == ST_WR_BYTE) && scl_fall && (bitcnt == 4'd8) && !ptr_pending;

    i2c_cmd_map #(.NREG(NREG)) u_map (
        .clk(clk), .rst_n(rst_n), .clr(tmo), .wr_en(wr_en), .wr_ptr(ptr),
        .wr_data(rx_sh), .rd_ptr(ptr), .alert_valid(alert_valid),
        .alert_src(alert_src), .word_o(word)
    );

    assign cur_byte = hi_sel ? word[15:8] : word[7:0];

    // next-state decision
    always_comb begin
        nxt = state;
        if (tmo)
            nxt = ST_IDLE;
        else if (start_det)
            nxt = ST_ADDR;
        else if (stop_det)
            nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_ADDR:     if (scl_fall && bitcnt == 4'd8)
                                 nxt = (rx_sh[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bitcnt == 4'd8) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mst_nack ? ST_IGNORE : ST_RD_BYTE;
                default:     nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0; rx_sh <= '0; tx_sh <= '0; ptr <= '0;
            ptr_pending <= 1'b0; hi_sel <= 1'b0; mst_nack <= 1'b0;
        end else if (tmo) begin
            bitcnt <= '0; tx_sh <= '0; ptr <= '0;
            ptr_pending <= 1'b0; hi_sel <= 1'b0; mst_nack <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
            hi_sel <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: if (scl_rise) begin
                    rx_sh  <= {rx_sh[6:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt      <= '0;
                    ptr_pending <= 1'b1;
                    if (rx_sh[0]) begin
                        tx_sh  <= cur_byte;
                        hi_sel <= ~hi_sel;
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8 && ptr_pending) begin
                        ptr         <= rx_sh;
                        ptr_pending <= 1'b0;
                    end
                end
                ST_WR_ACK: if (scl_fall) bitcnt <= '0;
                ST_RD_BYTE: if (scl_fall && bitcnt != 4'd7) begin
                    tx_sh  <= {tx_sh[6:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                end
                ST_RD_ACK: begin
                    if (scl_rise)
                        mst_nack <= sda_s;
                    else if (scl_fall && !mst_nack) begin
                        tx_sh  <= cur_byte;
                        hi_sel <= ~hi_sel;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sh[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !tmo) |=> (state == ST_ADDR)); // R1
    AST_BITCNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8); // R1
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE)); // R11
    AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det || stop_det || tmo)) |-> $stable(sda_oe)); // R9
    AST_TMO_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (state == ST_IDLE && ptr == 8'h00 && !sda_oe)); // R10
endmodule

// File: tb/i2c_reg_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_slave_tb_top;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int LOCK = 3000;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic alert_valid = 1'b0;
    logic [7:0] alert_src = 8'h00;
    logic sda_oe;
    logic sda_bus;

    int nchk = 0;
    int nerr = 0;
    int viol = 0;
    bit drive_ok = 0;

    logic [7:0] mregs [4];
    logic [7:0] mptr;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_reg_slave #(.DEV_ADDR(ADDR), .NREG(4), .LOCK_CYC(LOCK), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .alert_valid(alert_valid), .alert_src(alert_src), .sda_oe(sda_oe)
    );

    // per-clock model of when the slave is allowed to pull SDA (R9, R5)
    always @(negedge clk) begin
        if (rst_n && sda_oe && !drive_ok) begin
            viol++; nerr++; nchk++;
            $display("FAIL R9: sda_oe actual=1 expected=0 at %0t", $time);
        end
    end

    function automatic logic [15:0] word_of(input logic [7:0] p);
        if (p == 8'h09)      return 16'h0100;
        else if (p == 8'h0A) return alert_valid ? {8'h00, alert_src} : 16'h8103;
        else if (p < 8'd4)   return {8'h00, mregs[p[1:0]]};
        else                 return 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_slot(input logic val, input bit slave, output logic smp);
        drive_ok = drive_ok | slave;
        m_sda = slave ? 1'b1 : val;
        waitq(Q);
        drive_ok = slave;
        m_scl = 1'b1;
        waitq(Q);
        smp = sda_bus;
        waitq(Q);
        m_scl = 1'b0;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1;
        waitq(Q);
        drive_ok = 0;
        m_scl = 1'b1;
        waitq(Q);
        m_sda = 1'b0;
        waitq(Q);
        m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0;
        waitq(Q);
        drive_ok = 0;
        m_scl = 1'b1;
        waitq(Q);
        m_sda = 1'b1;
        waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, s);
        bit_slot(1'b1, 1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(1'b1, 1'b1, s);
            b[i] = s;
        end
        bit_slot(nack, 1'b0, s);
    endtask

    task automatic wr_txn(input logic [7:0] p, input logic [7:0] d, input bit with_data);
        logic ack;
        i2c_start();
        send_byte({ADDR, 1'b0}, ack); chk("R1 address ack", ack, 1);
        send_byte(p, ack);            chk("R2 pointer ack", ack, 1);
        mptr = p;
        if (with_data) begin
            send_byte(d, ack);        chk("R2 data ack", ack, 1);
            if (p < 8'd4) mregs[p[1:0]] = d;
        end
        i2c_stop();
    endtask

    task automatic rd_txn(input int n, input string req);
        logic ack;
        logic [7:0] b;
        logic [15:0] w;
        i2c_start();
        send_byte({ADDR, 1'b1}, ack); chk("R1 read address ack", ack, 1);
        w = word_of(mptr);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(req, b, (k % 2 == 1) ? w[15:8] : w[7:0]);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int v0;
        for (int i = 0; i < 4; i++) mregs[i] = 8'h00;
        mptr = 8'h00;
        repeat (5) @(negedge clk);
        chk("R12 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        waitq(20);
        chk("R12 sda_oe after reset", sda_oe, 0);
        rd_txn(2, "R12 reset pointer and register");

        // R2 R8 R3: plain register writes and readback
        wr_txn(8'h00, 8'h3C, 1);
        wr_txn(8'h01, 8'h5A, 1);
        wr_txn(8'h02, 8'hC3, 1);
        wr_txn(8'h01, 8'h00, 0);
        rd_txn(2, "R3 low then high byte");

        // R4: wrap to the low byte
        wr_txn(8'h02, 8'h00, 0);
        rd_txn(5, "R4 word wrap");

        // R6: version
        wr_txn(8'h09, 8'h00, 0);
        rd_txn(2, "R6 version word");

        // R7: alert source, idle then pending
        wr_txn(8'h0A, 8'h00, 0);
        rd_txn(2, "R7 no alert word");
        alert_src = 8'h22; alert_valid = 1'b1;
        rd_txn(2, "R7 alert source word");
        alert_valid = 1'b0;

        // R8: writes to a command are ignored, unmapped reads zero
        wr_txn(8'h09, 8'h77, 1);
        rd_txn(2, "R8 command not writable");
        wr_txn(8'h40, 8'h00, 0);
        rd_txn(2, "R8 unmapped reads zero");

        // R1: foreign address is ignored
        wr_txn(8'h01, 8'h00, 0);
        i2c_start();
        send_byte({ADDR ^ 7'h01, 1'b0}, ack); chk("R1 foreign address nack", ack, 0);
        send_byte(8'h02, ack);                chk("R1 foreign byte nack", ack, 0);
        i2c_stop();
        rd_txn(2, "R1 pointer unchanged by foreign address");

        // R1: repeated start between pointer write and read
        i2c_start();
        send_byte({ADDR, 1'b0}, ack); chk("R1 address ack", ack, 1);
        send_byte(8'h02, ack);        chk("R2 pointer ack", ack, 1);
        mptr = 8'h02;
        i2c_start();
        send_byte({ADDR, 1'b1}, ack); chk("R1 repeated start read ack", ack, 1);
        recv_byte(1'b0, b);           chk("R1 repeated start low byte", b, 8'hC3);
        recv_byte(1'b1, b);           chk("R1 repeated start high byte", b, 8'h00);
        i2c_stop();

        // R2: several data bytes land in the same register
        i2c_start();
        send_byte({ADDR, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h03, ack);        chk("R2 pointer ack", ack, 1);
        send_byte(8'h11, ack);        chk("R2 first data ack", ack, 1);
        send_byte(8'h99, ack);        chk("R2 second data ack", ack, 1);
        i2c_stop();
        mptr = 8'h03; mregs[3] = 8'h99;
        rd_txn(2, "R2 last byte kept, pointer fixed");

        // R5: NACK then extra clocks; the per-clock monitor watches the line
        v0 = viol;
        i2c_start();
        send_byte({ADDR, 1'b1}, ack); chk("R5 read ack", ack, 1);
        recv_byte(1'b1, b);           chk("R5 byte before nack", b, 8'h99);
        for (int i = 0; i < 9; i++) begin
            logic s;
            bit_slot(1'b1, 1'b0, s);
            chk("R5 line released after nack", s, 1);
        end
        i2c_stop();
        chk("R5 no pull-down after nack", viol - v0, 0);

        // R11: pointer kept across transactions
        rd_txn(2, "R11 pointer retained");

        // R10: stalled transaction returns to defaults
        i2c_start();
        send_byte({ADDR, 1'b0}, ack); chk("R10 address ack", ack, 1);
        send_byte(8'h01, ack);        chk("R10 pointer ack", ack, 1);
        waitq(LOCK + 1000);
        chk("R10 sda released after stall", sda_oe, 0);
        i2c_stop();
        mptr = 8'h00;
        for (int i = 0; i < 4; i++) mregs[i] = 8'h00;
        rd_txn(2, "R10 pointer and reg0 cleared");
        wr_txn(8'h02, 8'h00, 0);
        rd_txn(2, "R10 reg2 cleared");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule